// File: doc/BRIEF.md
# DMA Interrupt Aggregator

This block collects the interrupt flags of fifteen DMA channels and presents them to software in two views. The first view is a channel status word in the DMA register window. The second view is a two-level interrupt controller. It has a line-enable mask, a line-pending word and a summary word. The controller drives one interrupt request to the CPU. The channel datapaths sit outside the block, and each one delivers a level flag.

Channels 0 to 10 each own one interrupt line. Channels 11 to 14 are merged by OR onto line 11. In the pending word, line n appears at bit 16+n. The summary word sets bit 8 while any pending bit is set. Pending bits are levels: they follow the channel flags and the enable mask with no latching. Software acknowledges an interrupt at the channel and not in this block.

A single register port serves both windows. `ic_sel_i` selects between them: 0 is the DMA window and 1 is the controller window. Read data is registered.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, the enable mask is zero, every readable register returns zero and `irq_o` is low.
- R2: A read of DMA-window offset 0xFE0 returns bit n equal to channel flag n for n = 0..14, with bits 31:15 zero.
- R3: For n = 0..10, channel n drives interrupt line n. Line 11 is the OR of channels 11, 12, 13 and 14.
- R4: A read of controller offset 0x04 returns, at bit 16+n, line n ANDed with enable bit n, for n = 0..11. All other bits are zero.
- R5: A write to controller offset 0x10 sets enable bit n for each data bit 16+n that is 1. Zero bits, and bits outside 27:16, have no effect. Reading 0x10 returns the enable mask at bits 27:16.
- R6: A write to controller offset 0x1C clears enable bit n for each data bit 16+n that is 1. Reading 0x1C returns the same mask as 0x10.
- R7: A read of controller offset 0x00 returns bit 8 set exactly when the pending word of R4 is non-zero. All other bits are zero.
- R8: `irq_o` is high exactly when the summary word is non-zero. It follows the flag and enable inputs in the same cycle, and it is low whenever all flags are low.
- R9: A pending bit drops as soon as its channel flags drop, with no acknowledge write needed.
- R10: `rdata_o` loads on the rising edge where `req_i` is high and `we_i` is low, and holds at all other times. Unmapped offsets, and 0xFE0 in the controller window, read zero. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| ic_sel_i | input | 1 | 0 = DMA window, 1 = controller window |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| chan_flag_i | input | 15 | Per-channel interrupt flag levels |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The only state in this block is the enable mask. A bit that is wrongly set or cleared shows in two places. The next read of 0x10 or 0x1C returns it one cycle later. `irq_o` and the pending word also change as soon as the matching line is active. A mapping or gating fault carries no state, so it shows in the same cycle on `irq_o` and one cycle later in the pending read. The stimulus therefore mixes random flag and enable patterns with directed cases on the shared line and the line boundaries.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CH_STATUS = 12'hFE0;
  localparam logic [REG_AW-1:0] OFF_SUMMARY   = 12'h000;
  localparam logic [REG_AW-1:0] OFF_PENDING   = 12'h004;
  localparam logic [REG_AW-1:0] OFF_EN_SET    = 12'h010;
  localparam logic [REG_AW-1:0] OFF_EN_CLR    = 12'h01C;
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map #(
  parameter int unsigned NUM_CH  = 15,
  parameter int unsigned NUM_DED = 11,
  localparam int unsigned NUM_LINES = NUM_DED + 1
) (
  input  logic [NUM_CH-1:0]    flag_i,
  output logic [NUM_LINES-1:0] line_o
);
  for (genvar n = 0; n < NUM_DED; n++) begin : g_ded
    assign line_o[n] = flag_i[n];
  end

  // channels above the dedicated range share the last line
  if (NUM_CH > NUM_DED) begin : g_shared
    assign line_o[NUM_DED] = |flag_i[NUM_CH-1:NUM_DED];
  end else begin : g_no_shared
    assign line_o[NUM_DED] = 1'b0;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NUM_LINES = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] wmask_i,
  output logic [NUM_LINES-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= '0;
    else if (set_we_i) en_o <= en_o | wmask_i;
    else if (clr_we_i) en_o <= en_o & ~wmask_i;
  end

  p_enable_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_o & $past(wmask_i)) == $past(wmask_i)));

  p_enable_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((en_o & $past(wmask_i)) == '0));

  p_enable_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(en_o));
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ic_sel_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] status_word_i,
  input  logic [REG_DW-1:0] pending_word_i,
  input  logic [REG_DW-1:0] summary_word_i,
  input  logic [REG_DW-1:0] enable_word_i,
  output logic [REG_DW-1:0] rdata_o
);
  logic [REG_DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (!ic_sel_i) begin
      if (addr_i == OFF_CH_STATUS) rd_mux = status_word_i;
    end else begin
      unique case (addr_i)
        OFF_SUMMARY:            rd_mux = summary_word_i;
        OFF_PENDING:            rd_mux = pending_word_i;
        OFF_EN_SET, OFF_EN_CLR: rd_mux = enable_word_i;
        default:                rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_mux;
  end

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned NUM_DED   = 11,
  parameter int unsigned LINE_BASE = 16,
  parameter int unsigned AGGR_BIT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ic_sel_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic [NUM_CH-1:0] chan_flag_i,
  output logic              irq_o
);
  localparam int unsigned NUM_LINES = NUM_DED + 1;

  logic [NUM_LINES-1:0] line_vec;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] pend_lines;
  logic                 set_we, clr_we;
  logic [REG_DW-1:0]    status_word, pending_word, summary_word, enable_word;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;

  irq_line_map #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED)) u_map (
    .flag_i (chan_flag_i),
    .line_o (line_vec)
  );

  assign set_we = req_i && we_i && ic_sel_i && (addr_i == OFF_EN_SET);
  assign clr_we = req_i && we_i && ic_sel_i && (addr_i == OFF_EN_CLR);

  irq_enable_reg #(.NUM_LINES(NUM_LINES)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_we),
    .wmask_i  (wdata_i[LINE_BASE +: NUM_LINES]),
    .en_o     (en_q)
  );

  assign pend_lines = line_vec & en_q;

  always_comb begin
    status_word  = '0;
    pending_word = '0;
    summary_word = '0;
    enable_word  = '0;
    status_word[NUM_CH-1:0]               = chan_flag_i;
    pending_word[LINE_BASE +: NUM_LINES]  = pend_lines;
    enable_word[LINE_BASE +: NUM_LINES]   = en_q;
    summary_word[AGGR_BIT]                = |pending_word;
  end

  assign irq_o = |summary_word;

  irq_reg_read u_rd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .we_i           (we_i),
    .ic_sel_i       (ic_sel_i),
    .addr_i         (addr_i),
    .status_word_i  (status_word),
    .pending_word_i (pending_word),
    .summary_word_i (summary_word),
    .enable_word_i  (enable_word),
    .rdata_o        (rdata_o)
  );

  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_flag_i == '0) |-> !irq_o);

  p_irq_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(en_q & line_vec));

  p_shared_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_flag_i[NUM_CH-1:NUM_DED]) |-> line_vec[NUM_DED]);
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, ic_sel = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] flags = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [11:0] en_m = '0;

  always #4 clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .ic_sel_i(ic_sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .chan_flag_i(flags), .irq_o(irq)
  );

  function automatic logic [11:0] exp_lines(input logic [14:0] f);
    return {|f[14:11], f[10:0]};
  endfunction
  function automatic logic [31:0] exp_pend(input logic [14:0] f, input logic [11:0] e);
    return {4'b0, exp_lines(f) & e, 16'b0};
  endfunction
  function automatic logic [31:0] exp_summary(input logic [14:0] f, input logic [11:0] e);
    return (exp_pend(f, e) != 0) ? 32'h100 : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; ic_sel = sel; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
    if (sel && a == 12'h010) en_m = en_m | d[27:16];
    if (sel && a == 12'h01C) en_m = en_m & ~d[27:16];
  endtask

  task automatic rd(input logic sel, input logic [11:0] a, output logic [31:0] d);
    req = 1; we = 0; ic_sel = sel; addr = a;
    @(posedge clk); @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    #1 check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, exp_summary(flags, en_m) != 0});
    rd(0, 12'hFE0, v); check({tag, " R2 status"}, v, {17'b0, flags});
    rd(1, 12'h004, v); check({tag, " R4 pending"}, v, exp_pend(flags, en_m));
    rd(1, 12'h000, v); check({tag, " R7 summary"}, v, exp_summary(flags, en_m));
    rd(1, 12'h010, v); check({tag, " R5 enable"}, v, {4'b0, en_m, 16'b0});
    rd(1, 12'h01C, v); check({tag, " R6 enable"}, v, {4'b0, en_m, 16'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    #1 check("R1 irq", {31'b0, irq}, 32'h0);
    check_all("R1");

    // R3 dedicated line 0, enabled
    wr(1, 12'h010, 32'h0001_0000);
    flags = 15'h0001; @(negedge clk);
    check_all("R3 ch0");
    // R4 channel 10 without enable gives nothing
    flags = 15'h0400; @(negedge clk);
    check_all("R4 ch10 off");
    // R5 low bits ignored, then enable all lines
    wr(1, 12'h010, 32'hF000_FFFF);
    check_all("R5 ignore");
    wr(1, 12'h010, 32'h0FFF_0000);
    check_all("R5 all");
    // R3 shared line from channel 14 and from 11 plus 14
    flags = 15'h4000; @(negedge clk);
    check_all("R3 ch14");
    rd(1, 12'h004, v); check("R3 bit27", v, 32'h0800_0000);
    flags = 15'h4800; @(negedge clk);
    check_all("R3 ch11+14");
    // R9 level behaviour
    flags = 15'h0; @(negedge clk);
    check_all("R9 drop");
    rd(1, 12'h000, v); check("R9 summary clear", v, 32'h0);
    // R6 disable shared line
    wr(1, 12'h01C, 32'h0800_0000);
    flags = 15'h1000; @(negedge clk);
    check_all("R6 disabled");
    #1 check("R6 irq low", {31'b0, irq}, 32'h0);
    // R10 read-only writes, unmapped and wrong window
    wr(0, 12'hFE0, 32'hFFFF_FFFF);
    wr(1, 12'h004, 32'hFFFF_FFFF);
    wr(1, 12'h000, 32'hFFFF_FFFF);
    check_all("R10 ro");
    flags = 15'h0003; @(negedge clk);
    rd(1, 12'hFE0, v); check("R10 ic FE0", v, 32'h0);
    rd(1, 12'h008, v); check("R10 unmapped", v, 32'h0);
    rd(0, 12'h004, v); check("R10 dma 004", v, 32'h0);
    rd(0, 12'hFE0, v);
    flags = 15'h7FFF;
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, 32'h0000_0003);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      flags = 15'($urandom);
      case (r[1:0])
        2'd0: wr(1, 12'h010, $urandom);
        2'd1: wr(1, 12'h01C, $urandom);
        default: @(negedge clk);
      endcase
      check_all("rand R3");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule